// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

A sequential arithmetic unit that performs 32x32 multiplication and 32/32 division, in signed and unsigned forms, one operand bit per clock. A caller presents two operands and an operation code, pulses `start`, and some cycles later receives a `done` pulse together with a primary result, a secondary result and three flags: sign, zero and overflow. For multiplies the primary result is the low product word and the secondary result is the high word. For divides they are the quotient and the remainder.

The signed forms strip operand signs before the iterative loop and restore them afterwards. The loop is radix-2 shift-and-add for multiply and restoring subtraction for divide. A divide whose divisor is zero never enters the loop. It raises a one-cycle exception pulse with a fixed cause code and leaves every result and flag as it was. A start that arrives while an operation is in flight is dropped.

Top module: `muldiv_unit`

## Requirements
- R1: Operation code 2'b00 is signed multiply. The signed 64-bit product is split so that `result_lo` holds bits 31:0 and `result_hi` holds bits 63:32.
- R2: For signed multiply, `flag_ov` is 1 exactly when the product lies outside the signed 32-bit range.
- R3: Operation code 2'b01 is unsigned multiply. It gives the unsigned 64-bit product split the same way as R1, and `flag_ov` is 1 exactly when the product is above 0xFFFFFFFF.
- R4: Operation code 2'b10 is signed divide. The quotient is truncated toward zero and goes to `result_lo`. The remainder carries the dividend's sign and goes to `result_hi`. `flag_ov` is 0, except in the case covered by R6.
- R5: Operation code 2'b11 is unsigned divide. The quotient goes to `result_lo`, the remainder goes to `result_hi`, and `flag_ov` is 0.
- R6: Signed division of 0x80000000 by 0xFFFFFFFF yields quotient 0x80000000, remainder 0, `flag_ov`=1, `flag_s`=1 and `flag_z`=0.
- R7: A divide with a zero divisor produces no `done` pulse. Instead it raises `div_zero_exc` for one cycle, on the edge that samples `start`, with `exc_code` = 0xFF80 during that cycle. All results and flags keep their earlier values.
- R8: On every completed operation, `flag_s` equals bit 31 of `result_lo`, and `flag_z` is 1 exactly when `result_lo` is zero.
- R9: `done` is a one-cycle pulse set by the 34th rising edge, counting the edge that samples `start` as the first. Results and flags change only on that edge.
- R10: A `start` asserted while an operation is in progress is ignored. It leaves the running operation's results unaffected and does not produce an extra `done`.
- R11: After reset, all results, flags, `done`, `div_zero_exc` and `exc_code` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 2 | Operation code (see R1, R3, R4, R5) |
| opnd_a | input | 32 | Multiplicand or dividend |
| opnd_b | input | 32 | Multiplier or divisor |
| result_lo | output | 32 | Low product word or quotient |
| result_hi | output | 32 | High product word or remainder |
| flag_s | output | 1 | Sign of primary result |
| flag_z | output | 1 | Primary result is zero |
| flag_ov | output | 1 | Overflow |
| done | output | 1 | One-cycle completion pulse |
| div_zero_exc | output | 1 | One-cycle divide-by-zero pulse |
| exc_code | output | 16 | Cause code, valid with `div_zero_exc` |

## Verification
A normal operation's results and flags appear together with `done`, after the 34th rising edge, counting the edge that samples `start` as the first. A divide-by-zero exception is already visible after that first sampling edge. The driver records the cycle count when it raises `start` and stores the due cycle in each scoreboard entry. The monitor samples on falling edges, rejects any result that arrives early or late, and flags any pulse that has no matching entry. After an exception, and after a start that was ignored, the bench re-reads the held outputs to confirm they did not change.

// File: rtl/muldiv_pkg.sv
// Shared types for the iterative multiply/divide unit.
// Assumes the opcode MSB selects divide and the LSB selects unsigned.
package muldiv_pkg;

    typedef enum logic [1:0] {
        OP_SMUL = 2'b00,
        OP_UMUL = 2'b01,
        OP_SDIV = 2'b10,
        OP_UDIV = 2'b11
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_FIN  = 2'b10
    } md_state_e;

    localparam logic [15:0] DIV_ZERO_CODE = 16'hFF80;

    function automatic logic op_is_div(input md_op_e op);
        return op[1];
    endfunction

    function automatic logic op_is_signed(input md_op_e op);
        return ~op[0];
    endfunction

endpackage

// File: rtl/muldiv_ctrl.sv
// Sequencer: accepts a start in idle, runs WIDTH step cycles, then one
// finish cycle. Starts outside idle are dropped. A divide with a zero
// divisor fires the exception strobe and never leaves idle.
module muldiv_ctrl #(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic div_by_zero,
    output logic load,
    output logic step,
    output logic finish,
    output logic exc_fire
);
    import muldiv_pkg::*;

    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    md_state_e     state;
    logic [CW-1:0] cnt;

    // Decode the control strobes from the current state.
    always_comb begin
        load     = (state == ST_IDLE) && start && !div_by_zero;
        exc_fire = (state == ST_IDLE) && start && div_by_zero;
        step     = (state == ST_RUN);
        finish   = (state == ST_FIN);
    end

    // Advance the state machine and the iteration counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (load) begin
                    state <= ST_RUN;
                    cnt   <= '0;
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) state <= ST_FIN;
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/muldiv_mul_core.sv
// Radix-2 shift-add multiplier on unsigned magnitudes.
// One multiplier bit is consumed per step. After WIDTH steps, product
// holds the full 2*WIDTH-bit result. Assumes load and step never coincide.
module muldiv_mul_core #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic [2*WIDTH-1:0] product
);
    logic [WIDTH-1:0] mcand;
    logic [WIDTH-1:0] acc_hi;
    logic [WIDTH-1:0] acc_lo;
    logic [WIDTH:0]   sum;

    // Add the multiplicand when the current multiplier bit is set.
    always_comb begin
        sum = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, mcand} : '0);
    end

    // Load the operands, then shift the partial product right each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand  <= '0;
            acc_hi <= '0;
            acc_lo <= '0;
        end else if (load) begin
            mcand  <= mcand_in;
            acc_hi <= '0;
            acc_lo <= mplier_in;
        end else if (step) begin
            acc_hi <= sum[WIDTH:1];
            acc_lo <= {sum[0], acc_lo[WIDTH-1:1]};
        end
    end

    assign product = {acc_hi, acc_lo};

endmodule

// File: rtl/muldiv_div_core.sv
// Restoring divider on unsigned magnitudes.
// One quotient bit is produced per step, MSB first. Assumes a non-zero
// divisor (the controller filters zero) and that load and step never coincide.
module muldiv_div_core #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] dvnd_in,
    input  logic [WIDTH-1:0] dvsr_in,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder
);
    logic [WIDTH-1:0] dvsr;
    logic [WIDTH-1:0] rem;
    logic [WIDTH-1:0] quo;
    logic [WIDTH:0]   shifted;
    logic [WIDTH:0]   trial;

    // Shift the next dividend bit in and trial-subtract the divisor.
    always_comb begin
        shifted = {rem, quo[WIDTH-1]};
        trial   = shifted - {1'b0, dvsr};
    end

    // Keep the difference when it did not borrow, otherwise restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvsr <= '0;
            rem  <= '0;
            quo  <= '0;
        end else if (load) begin
            dvsr <= dvsr_in;
            rem  <= '0;
            quo  <= dvnd_in;
        end else if (step) begin
            if (!trial[WIDTH]) begin
                rem <= trial[WIDTH-1:0];
                quo <= {quo[WIDTH-2:0], 1'b1};
            end else begin
                rem <= shifted[WIDTH-1:0];
                quo <= {quo[WIDTH-2:0], 1'b0};
            end
        end
    end

    assign quotient  = quo;
    assign remainder = rem;

endmodule

// File: rtl/muldiv_unit.sv
// Iterative multiply/divide unit, top level.
// Signed operands are converted to magnitudes at load and the result signs
// are restored in the finish cycle. Outputs are registered and change only
// on done or stay put on a divide-by-zero exception.
module muldiv_unit #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result_lo,
    output logic [WIDTH-1:0] result_hi,
    output logic             flag_s,
    output logic             flag_z,
    output logic             flag_ov,
    output logic             done,
    output logic             div_zero_exc,
    output logic [15:0]      exc_code
);
    import muldiv_pkg::*;

    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    md_op_e           op_in;
    md_op_e           op_q;
    logic             a_neg, b_neg;
    logic [WIDTH-1:0] a_mag, b_mag;
    logic             div_by_zero;
    logic             load, step, finish, exc_fire;
    logic             neg_main_q, neg_rem_q, ov_spec_q;

    logic [2*WIDTH-1:0] product, prod_fix;
    logic [WIDTH-1:0]   quo_raw, rem_raw, quo_fix, rem_fix;
    logic [WIDTH-1:0]   prim_nx, sec_nx;
    logic               ov_nx;

    // Classify the request and take operand magnitudes.
    always_comb begin
        op_in       = md_op_e'(op);
        a_neg       = op_is_signed(op_in) && opnd_a[WIDTH-1];
        b_neg       = op_is_signed(op_in) && opnd_b[WIDTH-1];
        a_mag       = a_neg ? (~opnd_a + 1'b1) : opnd_a;
        b_mag       = b_neg ? (~opnd_b + 1'b1) : opnd_b;
        div_by_zero = op_is_div(op_in) && (opnd_b == '0);
    end

    muldiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .div_by_zero (div_by_zero),
        .load        (load),
        .step        (step),
        .finish      (finish),
        .exc_fire    (exc_fire)
    );

    muldiv_mul_core #(.WIDTH(WIDTH)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load && !op_is_div(op_in)),
        .step      (step && !op_is_div(op_q)),
        .mcand_in  (a_mag),
        .mplier_in (b_mag),
        .product   (product)
    );

    muldiv_div_core #(.WIDTH(WIDTH)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load && op_is_div(op_in)),
        .step      (step && op_is_div(op_q)),
        .dvnd_in   (a_mag),
        .dvsr_in   (b_mag),
        .quotient  (quo_raw),
        .remainder (rem_raw)
    );

    // Capture the operation and its sign-correction plan at load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= OP_SMUL;
            neg_main_q <= 1'b0;
            neg_rem_q  <= 1'b0;
            ov_spec_q  <= 1'b0;
        end else if (load) begin
            op_q       <= op_in;
            neg_main_q <= a_neg ^ b_neg;
            neg_rem_q  <= a_neg;
            ov_spec_q  <= (op_in == OP_SDIV) && (opnd_a == MOST_NEG)
                          && (opnd_b == ALL_ONES);
        end
    end

    // Restore signs and select the result words and the overflow rule.
    always_comb begin
        prod_fix = neg_main_q ? (~product + 1'b1) : product;
        quo_fix  = neg_main_q ? (~quo_raw + 1'b1) : quo_raw;
        rem_fix  = neg_rem_q  ? (~rem_raw + 1'b1) : rem_raw;
        case (op_q)
            OP_SMUL: begin
                prim_nx = prod_fix[WIDTH-1:0];
                sec_nx  = prod_fix[2*WIDTH-1:WIDTH];
                ov_nx   = (sec_nx != {WIDTH{prim_nx[WIDTH-1]}});
            end
            OP_UMUL: begin
                prim_nx = prod_fix[WIDTH-1:0];
                sec_nx  = prod_fix[2*WIDTH-1:WIDTH];
                ov_nx   = (sec_nx != '0);
            end
            default: begin
                prim_nx = quo_fix;
                sec_nx  = rem_fix;
                ov_nx   = ov_spec_q;
            end
        endcase
    end

    // Register the results and flags on the finish cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_lo <= '0;
            result_hi <= '0;
            flag_s    <= 1'b0;
            flag_z    <= 1'b0;
            flag_ov   <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                result_lo <= prim_nx;
                result_hi <= sec_nx;
                flag_s    <= prim_nx[WIDTH-1];
                flag_z    <= (prim_nx == '0);
                flag_ov   <= ov_nx;
            end
        end
    end

    // Raise the divide-by-zero pulse with its cause code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_zero_exc <= 1'b0;
            exc_code     <= '0;
        end else begin
            div_zero_exc <= exc_fire;
            exc_code     <= exc_fire ? DIV_ZERO_CODE : 16'h0000;
        end
    end

endmodule

// File: rtl/muldiv_unit_chk.sv
// Port-level checker for muldiv_unit, attached through bind.
module muldiv_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] result_lo,
    input logic [WIDTH-1:0] result_hi,
    input logic             flag_s,
    input logic             flag_z,
    input logic             flag_ov,
    input logic             done,
    input logic             div_zero_exc,
    input logic [15:0]      exc_code
);
    logic past_ok;

    // Mark cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R9: done lasts one cycle only.
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: results and flags change only together with done.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !done |-> ($stable(result_lo) && $stable(result_hi) && $stable(flag_s)
                   && $stable(flag_z) && $stable(flag_ov)));

    // R7: the exception carries its code and never comes with done.
    p_exc_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero_exc |-> (exc_code == 16'hFF80 && !done));

    // R7: no cause code is shown outside an exception.
    p_code_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !div_zero_exc |-> (exc_code == 16'h0000));

    // R8: sign and zero follow the primary result.
    p_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_s == result_lo[WIDTH-1] && flag_z == (result_lo == '0)));

endmodule

bind muldiv_unit muldiv_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .result_lo    (result_lo),
    .result_hi    (result_hi),
    .flag_s       (flag_s),
    .flag_z       (flag_z),
    .flag_ov      (flag_ov),
    .done         (done),
    .div_zero_exc (div_zero_exc),
    .exc_code     (exc_code)
);

// File: tb/muldiv_unit_bench.sv
module muldiv_unit_bench;

    localparam int LAT_OP  = 34;
    localparam int LAT_EXC = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result_lo, result_hi;
    logic        flag_s, flag_z, flag_ov, done, div_zero_exc;
    logic [15:0] exc_code;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        logic [31:0] lo;
        logic [31:0] hi;
        logic        s, z, ov, exc;
        int          due;
        string       tag;
    } exp_t;

    exp_t sb[$];

    muldiv_unit u_muldiv_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .result_lo(result_lo), .result_hi(result_hi),
        .flag_s(flag_s), .flag_z(flag_z), .flag_ov(flag_ov),
        .done(done), .div_zero_exc(div_zero_exc), .exc_code(exc_code)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [1:0] o, input logic [31:0] a,
                                   input logic [31:0] b, input string tag);
        exp_t e;
        logic [63:0] p;
        int qa, qb;
        e.tag = tag; e.exc = 1'b0; e.ov = 1'b0; e.due = 0;
        e.lo = '0; e.hi = '0;
        case (o)
            2'b00: begin
                p = 64'(longint'($signed(a)) * longint'($signed(b)));
                e.lo = p[31:0]; e.hi = p[63:32];
                e.ov = (e.hi != {32{e.lo[31]}});
            end
            2'b01: begin
                p = {32'h0, a} * {32'h0, b};
                e.lo = p[31:0]; e.hi = p[63:32];
                e.ov = (e.hi != 32'h0);
            end
            2'b10: begin
                if (b == 0) e.exc = 1'b1;
                else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
                    e.lo = 32'h8000_0000; e.hi = 0; e.ov = 1'b1;
                end else begin
                    qa = $signed(a); qb = $signed(b);
                    e.lo = 32'(qa / qb); e.hi = 32'(qa % qb);
                end
            end
            default: begin
                if (b == 0) e.exc = 1'b1;
                else begin e.lo = a / b; e.hi = a % b; end
            end
        endcase
        e.s = e.lo[31];
        e.z = (e.lo == 0);
        return e;
    endfunction

    // Driver: push the expected item, then pulse start for one edge.
    task automatic issue(input logic [1:0] o, input logic [31:0] a,
                         input logic [31:0] b, input string tag);
        exp_t e;
        @(negedge clk);
        e = model(o, a, b, tag);
        e.due = cyc + (e.exc ? LAT_EXC : LAT_OP);
        sb.push_back(e);
        op = o; opnd_a = a; opnd_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pop and compare as results and exceptions appear.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done || div_zero_exc) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R10", "unexpected pulse", {62'h0, done, div_zero_exc}, 64'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(cyc == e.due, "R9", {e.tag, " latency"}, 64'(cyc), 64'(e.due));
                    chk(div_zero_exc == e.exc, e.exc ? "R7" : e.tag, "exception",
                        64'(div_zero_exc), 64'(e.exc));
                    if (e.exc) begin
                        chk(exc_code == 16'hFF80, "R7", "code", 64'(exc_code), 64'hFF80);
                    end else begin
                        chk(result_lo == e.lo, e.tag, "result_lo", 64'(result_lo), 64'(e.lo));
                        chk(result_hi == e.hi, e.tag, "result_hi", 64'(result_hi), 64'(e.hi));
                        chk(flag_ov == e.ov, e.tag, "flag_ov", 64'(flag_ov), 64'(e.ov));
                        chk(flag_s == e.s && flag_z == e.z, "R8", {e.tag, " s/z"},
                            {62'h0, flag_s, flag_z}, {62'h0, e.s, e.z});
                    end
                end
            end else if (sb.size() != 0 && cyc > sb[0].due) begin
                exp_t e;
                e = sb.pop_front();
                chk(1'b0, "R9", {e.tag, " missing result"}, 64'(cyc), 64'(e.due));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] keep_lo, keep_hi;
        logic [2:0]  keep_f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(result_lo == 0 && result_hi == 0, "R11", "results", {result_hi, result_lo}, 64'h0);
        chk({flag_s, flag_z, flag_ov, done, div_zero_exc} == 0 && exc_code == 0, "R11",
            "flags/pulses", {43'h0, exc_code, flag_s, flag_z, flag_ov, done, div_zero_exc}, 64'h0);

        issue(2'b00, 32'd7, 32'hFFFF_FFFD, "R1");             drain();
        issue(2'b00, 32'h1234_5678, 32'h9ABC_DEF0, "R1");     drain();
        issue(2'b00, 32'h7FFF_FFFF, 32'd2, "R2");             drain();
        issue(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");     drain();
        issue(2'b00, 32'h8000_0000, 32'hFFFF_FFFF, "R2");     drain();
        issue(2'b00, 32'h0, 32'h5555_AAAA, "R8");             drain();
        issue(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");     drain();
        issue(2'b01, 32'h0001_0000, 32'h0000_FFFF, "R3");     drain();
        issue(2'b01, 32'h0001_0000, 32'h0001_0000, "R3");     drain();
        issue(2'b01, 32'hDEAD_BEEF, 32'h0, "R3");             drain();
        issue(2'b10, 32'hFFFF_FFF9, 32'd2, "R4");             drain();
        issue(2'b10, 32'd7, 32'hFFFF_FFFE, "R4");             drain();
        issue(2'b10, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R4");     drain();
        issue(2'b10, 32'd5, 32'd7, "R4");                     drain();
        issue(2'b10, 32'h8000_0000, 32'd1, "R4");             drain();
        issue(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, "R6");     drain();
        issue(2'b11, 32'hFFFF_FFFF, 32'd3, "R5");             drain();
        issue(2'b11, 32'd100, 32'd7, "R5");                   drain();
        issue(2'b11, 32'h8000_0000, 32'hFFFF_FFFF, "R5");     drain();

        // R7: zero divisor leaves results and flags untouched
        keep_lo = result_lo; keep_hi = result_hi; keep_f = {flag_s, flag_z, flag_ov};
        issue(2'b10, 32'd42, 32'h0, "R7");                    drain();
        issue(2'b11, 32'hFFFF_FFFF, 32'h0, "R7");             drain();
        chk(result_lo == keep_lo && result_hi == keep_hi, "R7", "held results",
            {result_hi, result_lo}, {keep_hi, keep_lo});
        chk({flag_s, flag_z, flag_ov} == keep_f, "R7", "held flags",
            64'({flag_s, flag_z, flag_ov}), 64'(keep_f));

        // R10: second start during a run is dropped
        issue(2'b01, 32'd1000, 32'd3000, "R10");
        repeat (5) @(negedge clk);
        op = 2'b11; opnd_a = 32'd9; opnd_b = 32'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        op = 2'b00; opnd_a = 32'd5; opnd_b = 32'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drain();
        repeat (40) @(negedge clk);
        // R9: outputs hold long after done
        chk(result_lo == 32'd3000000 && result_hi == 0, "R10", "result after ignored starts",
            {result_hi, result_lo}, {32'h0, 32'd3000000});

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule